// File: doc/BRIEF.md
# Configuration Window Gate for a Task-File Port Decoder

This block sits beside the I/O port decoder of a disk interface whose small offsets normally reach the task-file registers. A hidden set of configuration registers sits behind the same offsets. The block opens a configuration window only after it sees a fixed access sequence. While the window is open, an access to offset N reaches configuration register N. A closing key write returns the port to ordinary task-file decoding. The task-file registers are outside this block. The host logic uses `win_open` to steer accesses away from them.

The configuration set has the following registers:
- a read-cycle timing byte at offset 0;
- a write-cycle timing byte at offset 1;
- a control byte at offset 3;
- a read-only version byte at offset 5;
- a miscellaneous byte at offset 6.

The timing bytes exist once per timing bank. A control value with both top bits set enables the extra banks. Bit 0 of the miscellaneous byte then picks which bank offsets 0 and 1 reach.

A four-state machine tracks the unlock sequence. Its states are `ST_LOCKED`, `ST_SEEN1`, `ST_SEEN2` and `ST_OPEN`. Its transitions are:
- **first-read**: `ST_LOCKED` to `ST_SEEN1`, on a 16-bit read of offset 1.
- **second-read**: `ST_SEEN1` to `ST_SEEN2`, on another 16-bit read of offset 1.
- **key-open**: `ST_SEEN2` to `ST_OPEN`, on a byte write of 0x03 to offset 2.
- **break**: `ST_SEEN1` or `ST_SEEN2` to `ST_LOCKED`, on any other access.
- **key-close**: `ST_OPEN` to `ST_LOCKED`, on a byte write of 0x83 to offset 2.

Cycles with no strobe leave every state unchanged.

Top module: `cfg_window_gate`

## Requirements
- R1: After reset, `win_open` is 0, `cfg_sel` is 0 and `cfg_rdata` is 0, and every writable configuration register holds 0.
- R2: Three accesses in a row open the window: a read with `wide`=1 at offset 1, a second such read, then a write with `wide`=0 of low byte 0x03 at offset 2. `win_open` rises in the cycle after the clock edge that takes the key write.
- R3: Any strobed access that does not continue the unlock sequence sends the machine back to its start. This includes a byte-wide read of offset 1, an access to another offset, a third read, or a wide key write. The window then stays closed.
- R4: While the window is closed, `cfg_rdata` and `cfg_sel` are 0, and writes leave every configuration register unchanged.
- R5: While the window is open, `cfg_sel` equals `io_offset`. A write at offset 0, 1, 3 or 6 stores `wr_data` in that register from the next cycle, and `cfg_rdata` shows the register at `io_offset` in the same cycle.
- R6: Offset 5 reads the parameter `VERSION` (default 0), and writes to it are ignored.
- R7: While the window is open, offsets 2, 4 and 7 read 0, and writes to them store nothing.
- R8: A write with `wide`=0 of 0x83 to offset 2 closes the window; `win_open` is 0 in the cycle after that edge. A wide write of 0x83, or any other value at offset 2, leaves it open.
- R9: When control bits [7:6] are both 1, bit 0 of the misc register selects timing bank 0 or 1 for offsets 0 and 1. Otherwise bank 0 is always used.
- R10: The configuration registers keep their values while the window is closed and after it is reopened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_offset | input | OFS_W | I/O offset within the task-file block |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access (wins over rd_stb) |
| wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| wr_data | input | REG_W | Write data (low byte of the bus) |
| win_open | output | 1 | Configuration window is open |
| cfg_sel | output | OFS_W | Selected configuration register index, 0 when closed |
| cfg_rdata | output | REG_W | Read data of the selected register, 0 when closed |

## Verification
The bench builds the block with its default parameters: a 3-bit offset, 8-bit registers, two timing banks and a version byte of 0. Two banks make it possible to show a bank switch through the control and misc registers. The 3-bit offset reaches every defined and undefined offset, including 7. With a zero version byte, a write to offset 5 that wrongly landed would show up as a nonzero read-back.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_SEEN1  = 2'd1,
        ST_SEEN2  = 2'd2,
        ST_OPEN   = 2'd3
    } gate_state_t;

    // Offsets whose meaning the host relies on
    localparam int unsigned OFS_RDT   = 0;  // read-cycle timing
    localparam int unsigned OFS_WRT   = 1;  // write-cycle timing, also the unlock read offset
    localparam int unsigned OFS_KEY   = 2;  // key write offset
    localparam int unsigned OFS_CTRL  = 3;  // control
    localparam int unsigned OFS_VER   = 5;  // version, read-only
    localparam int unsigned OFS_MISC  = 6;  // misc / bank pick

    localparam logic [7:0] KEY_OPEN  = 8'h03;
    localparam logic [7:0] KEY_CLOSE = 8'h83;

endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
    import cfg_window_pkg::*;
#(
    parameter int unsigned OFS_W = 3,
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] io_offset,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             wide,
    input  logic [REG_W-1:0] wr_data,
    output logic             open_o
);

    localparam logic [OFS_W-1:0] RD_OFS  = OFS_W'(OFS_WRT);
    localparam logic [OFS_W-1:0] KEY_OFS = OFS_W'(OFS_KEY);

    gate_state_t state_q, state_d;

    logic any_acc;
    logic ev_rd1;
    logic ev_key_open;
    logic ev_key_close;

    always_comb begin
        any_acc      = rd_stb | wr_stb;
        ev_rd1       = rd_stb && !wr_stb && wide && (io_offset == RD_OFS);
        ev_key_open  = wr_stb && !wide && (io_offset == KEY_OFS)
                       && (wr_data[7:0] == KEY_OPEN);
        ev_key_close = wr_stb && !wide && (io_offset == KEY_OFS)
                       && (wr_data[7:0] == KEY_CLOSE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (ev_rd1) state_d = ST_SEEN1;            // first-read
            end
            ST_SEEN1: begin
                if (ev_rd1)       state_d = ST_SEEN2;      // second-read
                else if (any_acc) state_d = ST_LOCKED;     // break
            end
            ST_SEEN2: begin
                if (ev_key_open)  state_d = ST_OPEN;       // key-open
                else if (any_acc) state_d = ST_LOCKED;     // break
            end
            ST_OPEN: begin
                if (ev_key_close) state_d = ST_LOCKED;     // key-close
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        open_o = (state_q == ST_OPEN);
    end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
    import cfg_window_pkg::*;
#(
    parameter int unsigned OFS_W = 3,
    parameter int unsigned REG_W = 8,
    parameter int unsigned NBANK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             wr_stb,
    input  logic [OFS_W-1:0] io_offset,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rdt_o,
    output logic [REG_W-1:0] wrt_o,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] misc_o
);

    localparam int unsigned BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [REG_W-1:0] ctrl_q, misc_q;
    logic [REG_W-1:0] rdt_q [NBANK];
    logic [REG_W-1:0] wrt_q [NBANK];
    logic             bank_en;
    logic [BSEL_W-1:0] bank_idx;
    logic             we;

    always_comb begin
        we       = open_i && wr_stb;
        bank_en  = (ctrl_q[REG_W-1 -: 2] == 2'b11);
        bank_idx = bank_en ? misc_q[BSEL_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            misc_q <= '0;
        end else if (we) begin
            if (io_offset == OFS_W'(OFS_CTRL)) ctrl_q <= wr_data;
            if (io_offset == OFS_W'(OFS_MISC)) misc_q <= wr_data;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdt_q[b] <= '0;
                wrt_q[b] <= '0;
            end else if (we && (bank_idx == BSEL_W'(b))) begin
                if (io_offset == OFS_W'(OFS_RDT)) rdt_q[b] <= wr_data;
                if (io_offset == OFS_W'(OFS_WRT)) wrt_q[b] <= wr_data;
            end
        end
    end

    always_comb begin
        rdt_o  = rdt_q[bank_idx];
        wrt_o  = wrt_q[bank_idx];
        ctrl_o = ctrl_q;
        misc_o = misc_q;
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_window_pkg::*;
#(
    parameter int unsigned OFS_W   = 3,
    parameter int unsigned REG_W   = 8,
    parameter logic [7:0]  VERSION = 8'h00
) (
    input  logic             open_i,
    input  logic [OFS_W-1:0] io_offset,
    input  logic [REG_W-1:0] rdt_i,
    input  logic [REG_W-1:0] wrt_i,
    input  logic [REG_W-1:0] ctrl_i,
    input  logic [REG_W-1:0] misc_i,
    output logic [OFS_W-1:0] sel_o,
    output logic [REG_W-1:0] rdata_o
);

    always_comb begin
        sel_o   = open_i ? io_offset : '0;
        rdata_o = '0;
        if (open_i) begin
            case (int'(io_offset))
                OFS_RDT:  rdata_o = rdt_i;
                OFS_WRT:  rdata_o = wrt_i;
                OFS_CTRL: rdata_o = ctrl_i;
                OFS_VER:  rdata_o = REG_W'(VERSION);
                OFS_MISC: rdata_o = misc_i;
                default:  rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfg_window_gate.sv
module cfg_window_gate
    import cfg_window_pkg::*;
#(
    parameter int unsigned OFS_W   = 3,
    parameter int unsigned REG_W   = 8,
    parameter int unsigned NBANK   = 2,
    parameter logic [7:0]  VERSION = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] io_offset,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             wide,
    input  logic [REG_W-1:0] wr_data,
    output logic             win_open,
    output logic [OFS_W-1:0] cfg_sel,
    output logic [REG_W-1:0] cfg_rdata
);

    logic             open_w;
    logic [REG_W-1:0] rdt_w, wrt_w, ctrl_w, misc_w;

    cfg_unlock_fsm #(.OFS_W(OFS_W), .REG_W(REG_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_offset (io_offset),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wide      (wide),
        .wr_data   (wr_data),
        .open_o    (open_w)
    );

    cfg_reg_store #(.OFS_W(OFS_W), .REG_W(REG_W), .NBANK(NBANK)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (open_w),
        .wr_stb    (wr_stb),
        .io_offset (io_offset),
        .wr_data   (wr_data),
        .rdt_o     (rdt_w),
        .wrt_o     (wrt_w),
        .ctrl_o    (ctrl_w),
        .misc_o    (misc_w)
    );

    cfg_read_mux #(.OFS_W(OFS_W), .REG_W(REG_W), .VERSION(VERSION)) u_mux (
        .open_i    (open_w),
        .io_offset (io_offset),
        .rdt_i     (rdt_w),
        .wrt_i     (wrt_w),
        .ctrl_i    (ctrl_w),
        .misc_i    (misc_w),
        .sel_o     (cfg_sel),
        .rdata_o   (cfg_rdata)
    );

    assign win_open = open_w;

endmodule

// File: rtl/cfg_window_gate_chk.sv
module cfg_window_gate_chk #(
    parameter int unsigned OFS_W   = 3,
    parameter int unsigned REG_W   = 8,
    parameter logic [7:0]  VERSION = 8'h00
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OFS_W-1:0] io_offset,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic             wide,
    input logic [REG_W-1:0] wr_data,
    input logic             win_open,
    input logic [OFS_W-1:0] cfg_sel,
    input logic [REG_W-1:0] cfg_rdata
);

    logic key_close, key_open;
    assign key_close = wr_stb && !wide && (io_offset == OFS_W'(2)) && (wr_data[7:0] == 8'h83);
    assign key_open  = wr_stb && !wide && (io_offset == OFS_W'(2)) && (wr_data[7:0] == 8'h03);

    a_r4_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |-> (cfg_rdata == '0) && (cfg_sel == '0));

    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(key_open));

    a_r8_close_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && key_close) |=> !win_open);

    a_r6_version: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && io_offset == OFS_W'(5)) |-> cfg_rdata == REG_W'(VERSION));

    a_r7_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && (io_offset == OFS_W'(2) || io_offset == OFS_W'(4) || io_offset == OFS_W'(7)))
        |-> cfg_rdata == '0);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_open) && win_open && !$past(wr_stb) && $stable(io_offset))
        |-> $stable(cfg_rdata));

endmodule

bind cfg_window_gate cfg_window_gate_chk #(.OFS_W(OFS_W), .REG_W(REG_W), .VERSION(VERSION)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_offset (io_offset),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wide      (wide),
    .wr_data   (wr_data),
    .win_open  (win_open),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata)
);

// File: tb/cfg_window_gate_tb.sv
module cfg_window_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] io_offset = '0;
    logic       rd_stb = 1'b0, wr_stb = 1'b0, wide = 1'b0;
    logic [7:0] wr_data = '0;
    logic       win_open;
    logic [2:0] cfg_sel;
    logic [7:0] cfg_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_window_gate u_dut (
        .clk(clk), .rst_n(rst_n), .io_offset(io_offset), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wide(wide), .wr_data(wr_data),
        .win_open(win_open), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata)
    );

    localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

    // {op, offset, wide, data, expected open, expected rdata} sampled before the op's edge
    localparam int NVEC = 18;
    localparam logic [22:0] VEC [NVEC] = '{
        {OP_RD,   3'd1, 1'b1, 8'h00, 1'b0, 8'h00},  // R2 first read
        {OP_RD,   3'd1, 1'b1, 8'h00, 1'b0, 8'h00},  // R2 second read
        {OP_WR,   3'd2, 1'b0, 8'h03, 1'b0, 8'h00},  // R2 key
        {OP_IDLE, 3'd5, 1'b0, 8'h00, 1'b1, 8'h00},  // R2 open, R6 version
        {OP_WR,   3'd0, 1'b0, 8'h2A, 1'b1, 8'h00},  // R5
        {OP_RD,   3'd0, 1'b1, 8'h00, 1'b1, 8'h2A},  // R5
        {OP_WR,   3'd1, 1'b0, 8'h51, 1'b1, 8'h00},  // R5
        {OP_RD,   3'd1, 1'b0, 8'h00, 1'b1, 8'h51},  // R5
        {OP_WR,   3'd6, 1'b0, 8'h31, 1'b1, 8'h00},  // R5
        {OP_RD,   3'd6, 1'b0, 8'h00, 1'b1, 8'h31},  // R5
        {OP_WR,   3'd4, 1'b0, 8'hFF, 1'b1, 8'h00},  // R7
        {OP_RD,   3'd4, 1'b0, 8'h00, 1'b1, 8'h00},  // R7
        {OP_WR,   3'd5, 1'b0, 8'h77, 1'b1, 8'h00},  // R6
        {OP_RD,   3'd5, 1'b0, 8'h00, 1'b1, 8'h00},  // R6
        {OP_WR,   3'd2, 1'b1, 8'h83, 1'b1, 8'h00},  // R8 wide close ignored
        {OP_IDLE, 3'd0, 1'b0, 8'h00, 1'b1, 8'h2A},  // R8 still open, R9 bank 0
        {OP_WR,   3'd2, 1'b0, 8'h83, 1'b1, 8'h00},  // R8 byte close
        {OP_IDLE, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00}   // R8 closed, R4
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns later, pass one rising edge, drop strobes
    task automatic step(input logic [1:0] op, input logic [2:0] ofs, input logic wd,
                        input logic [7:0] dat, output logic o_open, output logic [7:0] o_rd);
        @(negedge clk);
        io_offset = ofs; wide = wd; wr_data = dat;
        rd_stb = (op == OP_RD); wr_stb = (op == OP_WR);
        #1;
        o_open = win_open; o_rd = cfg_rdata;
        @(posedge clk);
        #1;
        rd_stb = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic peek(input logic [2:0] ofs, output logic o_open, output logic [7:0] o_rd);
        step(OP_IDLE, ofs, 1'b0, 8'h00, o_open, o_rd);
    endtask

    task automatic unlock();
        logic o; logic [7:0] r;
        step(OP_RD, 3'd1, 1'b1, 8'h00, o, r);
        step(OP_RD, 3'd1, 1'b1, 8'h00, o, r);
        step(OP_WR, 3'd2, 1'b0, 8'h03, o, r);
    endtask

    task automatic wr(input logic [2:0] ofs, input logic [7:0] dat);
        logic o; logic [7:0] r;
        step(OP_WR, ofs, 1'b0, dat, o, r);
    endtask

    initial begin
        logic o;
        logic [7:0] r;

        // R1 reset state
        #1;
        check("R1 open", int'(win_open), 0);
        check("R1 sel", int'(cfg_sel), 0);
        check("R1 rdata", int'(cfg_rdata), 0);
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][22:21], VEC[i][20:18], VEC[i][17], VEC[i][16:9], o, r);
            check($sformatf("R2/R5/R6/R7/R8 vec%0d open", i), int'(o), int'(VEC[i][8]));
            check($sformatf("R5 vec%0d rdata", i), int'(r), int'(VEC[i][7:0]));
        end

        // R3 broken sequences
        step(OP_RD, 3'd1, 1'b1, 0, o, r);
        step(OP_RD, 3'd1, 1'b0, 0, o, r);                 // byte read breaks
        step(OP_WR, 3'd2, 1'b0, 8'h03, o, r);
        peek(3'd0, o, r); check("R3 byte read", int'(o), 0);
        step(OP_RD, 3'd1, 1'b1, 0, o, r);
        step(OP_RD, 3'd1, 1'b1, 0, o, r);
        step(OP_RD, 3'd0, 1'b1, 0, o, r);                 // other offset breaks
        step(OP_WR, 3'd2, 1'b0, 8'h03, o, r);
        peek(3'd0, o, r); check("R3 other offset", int'(o), 0);
        step(OP_RD, 3'd1, 1'b1, 0, o, r);
        step(OP_RD, 3'd1, 1'b1, 0, o, r);
        step(OP_RD, 3'd1, 1'b1, 0, o, r);                 // third read breaks
        step(OP_WR, 3'd2, 1'b0, 8'h03, o, r);
        peek(3'd0, o, r); check("R3 third read", int'(o), 0);
        step(OP_RD, 3'd1, 1'b1, 0, o, r);
        step(OP_RD, 3'd1, 1'b1, 0, o, r);
        step(OP_WR, 3'd2, 1'b1, 8'h03, o, r);             // wide key breaks
        peek(3'd0, o, r); check("R3 wide key", int'(o), 0);
        check("R4 closed sel", int'(cfg_sel), 0);

        // R4 writes while closed; R10 retention
        wr(3'd0, 8'h99);
        wr(3'd6, 8'hEE);
        unlock();
        peek(3'd0, o, r);
        check("R2 reopen", int'(o), 1);
        check("R4/R10 ofs0 kept", int'(r), 8'h2A);
        peek(3'd6, o, r); check("R4/R10 misc kept", int'(r), 8'h31);
        peek(3'd6, o, r); check("R5 sel", int'(cfg_sel), 6);
        wr(3'd2, 8'h55);                                  // R8 other value at key offset
        peek(3'd2, o, r); check("R8 other value keeps open", int'(o), 1);

        // R9 bank switching (misc bit0 is 1 here)
        wr(3'd3, 8'hC0);
        peek(3'd3, o, r); check("R5 ctrl", int'(r), 8'hC0);
        peek(3'd0, o, r); check("R9 bank1 empty", int'(r), 0);
        wr(3'd0, 8'h5B);
        wr(3'd1, 8'h6C);
        peek(3'd1, o, r); check("R9 bank1 wrt", int'(r), 8'h6C);
        wr(3'd6, 8'h30);
        peek(3'd0, o, r); check("R9 bank0 rdt", int'(r), 8'h2A);
        peek(3'd1, o, r); check("R9 bank0 wrt", int'(r), 8'h51);
        wr(3'd6, 8'h01);
        peek(3'd0, o, r); check("R9 bank1 rdt", int'(r), 8'h5B);
        wr(3'd3, 8'h85);
        peek(3'd0, o, r); check("R9 bank off", int'(r), 8'h2A);

        // R1 reset while open
        @(negedge clk) rst_n = 1'b0;
        #1;
        check("R1 reset closes", int'(win_open), 0);
        @(negedge clk) rst_n = 1'b1;
        unlock();
        peek(3'd0, o, r); check("R1 rdt cleared", int'(r), 0);
        peek(3'd3, o, r); check("R1 ctrl cleared", int'(r), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule